// File: doc/BRIEF.md
# Halfband Interpolate-by-Two Filter

This block doubles the sample rate of a strobed stream of signed two's complement samples. Every accepted input yields two outputs. The first output is the filtered phase. It is a symmetric FIR sum built from pre-added sample pairs, which two time-shared multipliers work through over several clock cycles. The second output is the center-tap phase. Because the halfband center tap is one half and the path gain is two, this output is simply the input from several samples earlier, passed through with no multiply.

Tap weights are held in a small register bank that can be rewritten at run time. A length select chooses between a 31-tap response, which takes four multiply steps, and a 63-tap response, which takes eight. The longer response may only be chosen when inputs are spaced far enough apart to give it those extra cycles. Sample history is kept in plain registers. The history is shared by both lengths, so switching length does not lose past samples.

Top module: `hbi_interp`

## Requirements
- R1: While reset is asserted and afterwards until the first output, `out_stb` is 0 and `out_data` is 0. The sample history and all tap words reset to zero.
- R2: An input accepted on clock edge E0 (`in_stb` high) produces exactly two output strobes. Each strobe is high for one cycle. They follow edge E0+S+1 and edge E0+S+3, where S is 4 in short mode and 8 in long mode.
- R3: Let x[0] be the newest input and x[i] the input i strobes earlier, and let K be 8 (short) or 16 (long). The first output is A = sum over j<K of c[j]*(x[j]+x[2K-1-j]), where c[j] is the tap word stored at address j, then rounded and saturated as in R5 and R6.
- R4: The second output equals x[K-1] unchanged. It uses no multiplier.
- R5: Rounding adds 2^(CW-2) to A and then shifts arithmetically right by CW-1 bits. This makes the stored tap value c/2^CW and applies a gain of two. Exact halves round toward plus infinity.
- R6: A rounded result above 2^(DW-1)-1 or below -2^(DW-1) is clamped to that limit.
- R7: A write with `coef_we` high stores `coef_data` into the tap word at `coef_addr` on that clock edge. Inputs accepted after the write use the new value.
- R8: `long_mode` is sampled with each `in_stb`. After a long-mode input the next input must come at least 8 cycles later. After a short-mode input it must come at least 4 cycles later.
- R9: Output strobes are never high in two adjacent cycles.
- R10: Every input shifts one 32-entry history whatever the mode. Changing length therefore keeps the prior samples in the sums of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Input sample valid |
| in_data | input | DW | Input sample, signed |
| long_mode | input | 1 | 1 selects the 63-tap response for this input |
| coef_we | input | 1 | Tap word write enable |
| coef_addr | input | log2(NPAIR_L) | Tap word index j |
| coef_data | input | CW | Tap word value, signed |
| out_stb | output | 1 | Output sample valid |
| out_data | output | DW | Output sample, signed |

## Verification
The embedded assertions check several things on every cycle. Output strobes are never adjacent. A finished accumulation is followed at once by a filtered strobe. The center-phase strobe carries the held sample. The history shifts exactly when a sample is accepted, tap writes land at the addressed word, and input spacing respects the current length. The arithmetic of R3 through R6 can only be shown by the bench's behavioural model. The same applies to exact strobe timing, rounding of exact halves, clamping at both rails, taps rewritten between inputs, and history carried across a change of length.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // multipliers shared by the filtered phase
  localparam int HB_LANES = 2;
  typedef enum logic {HB_SHORT = 1'b0, HB_LONG = 1'b1} hb_len_e;
endpackage

// File: rtl/hbi_coef_bank.sv
module hbi_coef_bank import hbi_pkg::*; #(
  parameter int CW      = 18,
  parameter int NPAIR_L = 16,
  parameter int SW      = 3,
  parameter int CAW     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CAW-1:0]         addr,
  input  logic [CW-1:0]          wdata,
  input  logic [SW-1:0]          step,
  output logic [HB_LANES*CW-1:0] lane_coef
);
  logic [CW-1:0] coef_q [NPAIR_L];
  logic [CW-1:0] coef_d [NPAIR_L];

  always_comb begin
    for (int i = 0; i < NPAIR_L; i++) coef_d[i] = coef_q[i];
    if (we) coef_d[addr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR_L; i++) coef_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPAIR_L; i++) coef_q[i] <= coef_d[i];
    end
  end

  for (genvar l = 0; l < HB_LANES; l++) begin : g_lane
    logic [CAW-1:0] idx;
    assign idx = CAW'(step) * CAW'(HB_LANES) + CAW'(l);
    assign lane_coef[l*CW +: CW] = coef_q[idx];
  end

  // R7
  coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> coef_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/hbi_history.sv
module hbi_history import hbi_pkg::*; #(
  parameter int DW      = 16,
  parameter int NPAIR_S = 8,
  parameter int NPAIR_L = 16,
  parameter int SW      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [DW-1:0]              din,
  input  logic [SW-1:0]              step,
  input  logic                       long_sel,
  output logic [HB_LANES*(DW+1)-1:0] pairs,
  output logic [DW-1:0]              center
);
  localparam int DEPTH = 2 * NPAIR_L;
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = DW + 1;

  logic [DW-1:0] hist_q [DEPTH];
  logic [DW-1:0] hist_d [DEPTH];
  logic [IW-1:0] top_idx;
  logic [IW-1:0] ctr_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) hist_d[i] = hist_q[i];
    if (shift_en) begin
      hist_d[0] = din;
      for (int i = 1; i < DEPTH; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
    end
  end

  assign top_idx = long_sel ? IW'(DEPTH - 1)   : IW'(2 * NPAIR_S - 1);
  assign ctr_idx = long_sel ? IW'(NPAIR_L - 1) : IW'(NPAIR_S - 1);
  assign center  = hist_q[ctr_idx];

  for (genvar l = 0; l < HB_LANES; l++) begin : g_pair
    logic [IW-1:0] near_idx;
    logic [IW-1:0] far_idx;
    assign near_idx = IW'(step) * IW'(HB_LANES) + IW'(l);
    assign far_idx  = top_idx - near_idx;
    assign pairs[l*PW +: PW] = {hist_q[near_idx][DW-1], hist_q[near_idx]}
                             + {hist_q[far_idx][DW-1],  hist_q[far_idx]};
  end

  // R10
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(din)) && (hist_q[DEPTH-1] == $past(hist_q[DEPTH-2])));
  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q[0]) && $stable(hist_q[DEPTH-1]));
endmodule

// File: rtl/hbi_mac.sv
module hbi_mac import hbi_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int AW = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       clr,
  input  logic [HB_LANES*(DW+1)-1:0] pairs,
  input  logic [HB_LANES*CW-1:0]     coefs,
  output logic [DW-1:0]              result
);
  localparam int PW = DW + 1;
  localparam int MW = PW + CW;
  localparam logic signed [AW-1:0] RND  = AW'(64'sd1 <<< (CW - 2));
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] prod_x [HB_LANES];
  logic signed [AW-1:0] rnd, shr;

  for (genvar l = 0; l < HB_LANES; l++) begin : g_mul
    logic signed [MW-1:0] prod;
    assign prod      = $signed(pairs[l*PW +: PW]) * $signed(coefs[l*CW +: CW]);
    assign prod_x[l] = {{(AW-MW){prod[MW-1]}}, prod};
  end

  always_comb begin
    acc_d = clr ? '0 : acc_q;
    for (int l = 0; l < HB_LANES; l++) acc_d = acc_d + prod_x[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  always_comb begin
    rnd = acc_q + RND;
    shr = rnd >>> (CW - 1);
    if (shr > MAXV)      result = MAXV[DW-1:0];
    else if (shr < MINV) result = MINV[DW-1:0];
    else                 result = shr[DW-1:0];
  end

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/hbi_interp.sv
module hbi_interp import hbi_pkg::*; #(
  parameter int DW      = 16,
  parameter int CW      = 18,
  parameter int NPAIR_S = 8,
  parameter int NPAIR_L = 16,
  localparam int CAW    = $clog2(NPAIR_L)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_stb,
  input  logic [DW-1:0]  in_data,
  input  logic           long_mode,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [CW-1:0]  coef_data,
  output logic           out_stb,
  output logic [DW-1:0]  out_data
);
  localparam int STEPS_S = NPAIR_S / HB_LANES;
  localparam int STEPS_L = NPAIR_L / HB_LANES;
  localparam int SW      = $clog2(STEPS_L);
  localparam int AW      = DW + 1 + CW + CAW + 1;

  logic          run_q, run_d;
  logic [SW-1:0] cnt_q, cnt_d;
  hb_len_e       len_q, len_d;
  logic          fdone_q, fdone_d;
  logic [1:0]    ph_q, ph_d;
  logic [DW-1:0] ctr_q, ctr_d;
  logic          ostb_q, ostb_d;
  logic [DW-1:0] odat_q, odat_d;
  logic          last;
  logic          is_long;

  logic [HB_LANES*(DW+1)-1:0] pairs;
  logic [HB_LANES*CW-1:0]     lane_coef;
  logic [DW-1:0]              center;
  logic [DW-1:0]              filt;

  assign is_long = (len_q == HB_LONG);
  assign last    = (cnt_q == (is_long ? SW'(STEPS_L - 1) : SW'(STEPS_S - 1)));

  hbi_history #(.DW(DW), .NPAIR_S(NPAIR_S), .NPAIR_L(NPAIR_L), .SW(SW)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(in_stb), .din(in_data),
    .step(cnt_q), .long_sel(is_long), .pairs(pairs), .center(center));

  hbi_coef_bank #(.CW(CW), .NPAIR_L(NPAIR_L), .SW(SW), .CAW(CAW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
    .wdata(coef_data), .step(cnt_q), .lane_coef(lane_coef));

  hbi_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(run_q), .clr(cnt_q == '0),
    .pairs(pairs), .coefs(lane_coef), .result(filt));

  // sequencer and output next state
  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    fdone_d = 1'b0;
    ctr_d   = ctr_q;
    ph_d    = {ph_q[0], fdone_q};
    ostb_d  = 1'b0;
    odat_d  = odat_q;
    if (run_q) begin
      cnt_d = cnt_q + SW'(1);
      if (last) begin
        run_d   = 1'b0;
        fdone_d = 1'b1;
        ctr_d   = center;
      end
    end
    if (in_stb) begin
      run_d = 1'b1;
      cnt_d = '0;
      len_d = long_mode ? HB_LONG : HB_SHORT;
    end
    if (fdone_q) begin
      ostb_d = 1'b1;
      odat_d = filt;
    end else if (ph_q[1]) begin
      ostb_d = 1'b1;
      odat_d = ctr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= HB_SHORT;
      fdone_q <= 1'b0;
      ph_q    <= '0;
      ctr_q   <= '0;
      ostb_q  <= 1'b0;
      odat_q  <= '0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      fdone_q <= fdone_d;
      ph_q    <= ph_d;
      ctr_q   <= ctr_d;
      ostb_q  <= ostb_d;
      odat_q  <= odat_d;
    end
  end

  assign out_stb  = ostb_q;
  assign out_data = odat_q;

  // input spacing monitor
  logic [3:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= 4'd15;
    else if (in_stb)     gap_q <= 4'd1;
    else if (gap_q != 4'd15) gap_q <= gap_q + 4'd1;
  end

  // R8
  in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |-> gap_q >= (is_long ? 4'(STEPS_L) : 4'(STEPS_S)));
  // R9
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |=> !out_stb);
  // R2
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fdone_q |=> out_stb);
  // R4
  center_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q[1] && !fdone_q) |=> out_stb && (out_data == $past(ctr_q)));
endmodule

// File: tb/test_hbi_interp.sv
module test_hbi_interp;
  localparam int DW = 16;
  localparam int CW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_stb = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          long_mode = 1'b0;
  logic          coef_we = 1'b0;
  logic [3:0]    coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic          out_stb;
  logic [DW-1:0] out_data;

  hbi_interp i_hbi_interp (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_data(in_data),
    .long_mode(long_mode), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_stb(out_stb), .out_data(out_data));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int mh [32];
  int mc [16];
  int exp_cyc [$];
  int exp_val [$];
  string exp_req [$];

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic wr_coef(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = CW'(v);
    mc[a] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic send(input int x, input bit lng, input int gap, input string req);
    int k, s;
    longint acc;
    @(negedge clk);
    in_stb = 1'b1; in_data = DW'(x); long_mode = lng;
    for (int i = 31; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = x;
    k = lng ? 16 : 8;
    s = lng ? 8 : 4;
    acc = 0;
    for (int j = 0; j < k; j++) acc += longint'(mc[j]) * longint'(mh[j] + mh[2*k-1-j]);
    exp_cyc.push_back(cyc + s + 2);
    exp_val.push_back(sat((acc + 64'sd65536) >>> 17));
    exp_req.push_back({req, " filtered"});
    exp_cyc.push_back(cyc + s + 4);
    exp_val.push_back(mh[k-1]);
    exp_req.push_back("R4 center");
    @(negedge clk);
    in_stb = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom())));
  endfunction

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        checks++; fails++;
        $display("FAIL %s/R2: no strobe at cycle %0d (actual out_stb=0, expected 1, value %0d)",
                 exp_req[0], exp_cyc[0], exp_val[0]);
        void'(exp_cyc.pop_front()); void'(exp_val.pop_front()); void'(exp_req.pop_front());
      end
      if (out_stb) begin
        checks++;
        if (exp_cyc.size() == 0 || exp_cyc[0] != cyc) begin
          fails++;
          $display("FAIL R2/R9: unexpected strobe at cycle %0d (actual 1, expected 0)", cyc);
        end else begin
          if ($signed(out_data) != exp_val[0]) begin
            fails++;
            $display("FAIL %s: cycle %0d actual %0d expected %0d",
                     exp_req[0], cyc, $signed(out_data), exp_val[0]);
          end
          void'(exp_cyc.pop_front()); void'(exp_val.pop_front()); void'(exp_req.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mh[i] = 0;
    for (int i = 0; i < 16; i++) mc[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_stb !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1: during reset actual stb=%b data=%0d expected 0/0", out_stb, out_data);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (out_stb !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1: after reset actual stb=%b data=%0d expected 0/0", out_stb, out_data);
    end
    // R1: zero taps give zero filtered output
    send(1234, 1'b0, 4, "R1");

    // R7 short taps, R3 impulse at minimum spacing (R9)
    wr_coef(0, 300);   wr_coef(1, -1200); wr_coef(2, 2500); wr_coef(3, -4800);
    wr_coef(4, 8100);  wr_coef(5, -13000); wr_coef(6, 21000); wr_coef(7, 41000);
    send(10000, 1'b0, 4, "R3 impulse");
    for (int i = 0; i < 18; i++) send(0, 1'b0, 4, "R3 impulse tail");

    // R3 random stream, varied spacing
    for (int i = 0; i < 40; i++) send(rnd16(), 1'b0, 4 + (i % 3), "R3 random");

    // R5 exact halves round upward
    for (int i = 0; i < 16; i++) send(0, 1'b0, 4, "R5 clear");
    for (int j = 0; j < 8; j++) wr_coef(j, 0);
    wr_coef(0, 65536);
    send(3, 1'b0, 4, "R5 +1.5");
    send(-3, 1'b0, 4, "R5 -1.5");
    send(5, 1'b0, 4, "R5 +2.5");
    send(-7, 1'b0, 4, "R5 -3.5");

    // R6 saturation at both rails
    for (int j = 0; j < 8; j++) wr_coef(j, 131071);
    for (int i = 0; i < 18; i++) send(32767, 1'b0, 4, "R6 high");
    for (int i = 0; i < 18; i++) send(-32768, 1'b0, 4, "R6 low");

    // R7 rewrite taps between inputs
    wr_coef(3, -20000); wr_coef(5, 900);
    for (int i = 0; i < 10; i++) send(rnd16() / 4, 1'b0, 4, "R7 rewrite");

    // R8 long response, sixteen taps, spacing 8
    for (int j = 0; j < 16; j++) wr_coef(j, (j % 2 == 0) ? 1500 * (j + 1) : -900 * j);
    for (int i = 0; i < 40; i++) send(rnd16(), 1'b1, 8, "R8 long");

    // R10 history carried across length changes
    for (int i = 0; i < 12; i++) send(rnd16(), i[0], 8, "R10 switch");
    send(rnd16(), 1'b0, 4, "R10 short");
    send(rnd16(), 1'b1, 8, "R10 long");

    repeat (30) @(negedge clk);
    checks++;
    if (exp_cyc.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d outputs missing (actual pending %0d, expected 0)",
               exp_cyc.size(), exp_cyc.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule